// File: doc/BRIEF.md
# Single-step and branch trace trigger

This block watches the instruction completion stream of a processor core and raises a trace exception request whenever the trace enables in the machine state register ask for one. Two enables act independently. The step enable traces every instruction that retires cleanly. The branch enable traces only retiring branches. If both are set, a retiring branch still gives exactly one request.

The request is registered. It is a single-cycle pulse in the cycle after the completing instruction, and it carries the trace vector offset 0x00D00. An instruction that retires with its own exception does not count as a successful completion. While an exception is being taken, both enables are treated as cleared, so the handler's own instructions do not trigger tracing. The enables are read in the same cycle as the completion, so a change to the state register only affects instructions that complete after the change.

Top module: `trace_trigger`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `trace_req` is 0 and `trace_vec` is 0 after that edge, whatever the other inputs are.
- R2: When `msr_in` bit index 10 (the step enable; bit 21 when counted from the most significant bit as 0) is 1 and an instruction completes successfully (`cmp_valid`=1, `cmp_fault`=0, `exc_active`=0), `trace_req` is 1 in the next cycle, whether or not the instruction is a branch.
- R3: When only `msr_in` bit index 9 (the branch enable; bit 22 when counted from the most significant bit as 0) is set, a successful completion raises `trace_req` in the next cycle if `cmp_branch`=1, and does not raise it if `cmp_branch`=0.
- R4: With both enables clear, no completion raises `trace_req`.
- R5: A completion with `cmp_fault`=1 never raises `trace_req`.
- R6: Each qualifying completion produces exactly one single-cycle pulse. This includes a branch when both enables are set. A cycle without a qualifying completion leaves `trace_req` at 0 in the following cycle.
- R7: `trace_vec` is 20'h00D00 in every cycle in which `trace_req` is 1, and 0 otherwise.
- R8: The enables are taken from `msr_in` in the cycle in which `cmp_valid` is 1. Earlier values of the enables have no effect.
- R9: A completion in a cycle with `exc_active`=1 never raises `trace_req`.
- R10: The `msr_in` bits other than index 10 and index 9 have no effect on `trace_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msr_in | input | 32 | Machine state register; index 10 = step enable, index 9 = branch enable |
| cmp_valid | input | 1 | An instruction completes this cycle |
| cmp_branch | input | 1 | The completing instruction is a branch |
| cmp_fault | input | 1 | The completing instruction raised its own exception |
| exc_active | input | 1 | An exception is currently being taken |
| trace_req | output | 1 | Trace exception request, one cycle per qualifying completion |
| trace_vec | output | 20 | Vector offset of the request (0x00D00 when requesting, else 0) |

## Verification
The assertions check the following on every cycle:
- the pairing of the request with its vector offset;
- that a request is always preceded by a clean completion outside an exception;
- the step and branch firing rules;
- the absence of a request when no enable applies.

The bench's scenarios show what a single-cycle property cannot: that an enable change coinciding with a completion takes effect at once, that the state register bits other than the two enables are ignored, and that back-to-back completions give back-to-back pulses rather than one merged pulse. A reference model compares both outputs every cycle, over directed cases and a long pseudo-random stream.

// File: rtl/trace_trig_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types of the trace trigger.
// Assumes a 20-bit exception vector offset space.
package trace_trig_pkg;
    localparam int VEC_W = 20;
    localparam logic [VEC_W-1:0] TRACE_VEC_OFF = 20'h00D00;

    // Qualified enables after the exception-in-progress gate.
    typedef struct packed {
        logic step;
        logic branch;
    } trace_en_t;
endpackage

// File: rtl/trace_enable_gate.sv
`timescale 1ns/1ps
// Module: extracts the two trace enables from the machine state word
// and forces them off while an exception is being taken.
// Assumes the bit positions are valid indices of the state word.
module trace_enable_gate
    import trace_trig_pkg::*;
#(
    parameter int MSR_W      = 32,
    parameter int STEP_BIT   = 10,
    parameter int BRANCH_BIT = 9
) (
    input  logic [MSR_W-1:0] msr_in,
    input  logic             exc_active,
    output trace_en_t        en_out
);
    // Remaining state bits are deliberately ignored.
    logic unused_msr_rest;
    assign unused_msr_rest = ^msr_in;

    // Qualify each enable with the exception-in-progress indication.
    always_comb begin
        en_out.step   = msr_in[STEP_BIT]   & ~exc_active;
        en_out.branch = msr_in[BRANCH_BIT] & ~exc_active;
    end
endmodule

// File: rtl/trace_event_select.sv
`timescale 1ns/1ps
// Module: decides whether the instruction completing this cycle earns a
// trace request. Assumes at most one completion per cycle.
module trace_event_select
    import trace_trig_pkg::*;
(
    input  logic      cmp_valid,
    input  logic      cmp_branch,
    input  logic      cmp_fault,
    input  trace_en_t en_in,
    output logic      fire
);
    logic clean_done;

    // A completion counts only when it raised no exception of its own.
    always_comb begin
        clean_done = cmp_valid & ~cmp_fault;
        fire       = clean_done & (en_in.step | (en_in.branch & cmp_branch));
    end
endmodule

// File: rtl/trace_request_reg.sv
`timescale 1ns/1ps
// Module: registers the trace decision into a one-cycle request and its
// vector offset. Assumes a synchronous active-low reset.
module trace_request_reg
    import trace_trig_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    output logic             req,
    output logic [VEC_W-1:0] vec
);
    // Capture the decision; the pulse ends unless another completion qualifies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= 1'b0;
            vec <= '0;
        end else begin
            req <= fire;
            vec <= fire ? TRACE_VEC_OFF : '0;
        end
    end
endmodule

// File: rtl/trace_trigger.sv
`timescale 1ns/1ps
// Module: top of the single-step and branch trace trigger.
// Samples the enables together with each completion and emits one
// registered trace request per qualifying instruction.
// Assumes the completion interface reports one instruction per cycle.
module trace_trigger
    import trace_trig_pkg::*;
#(
    parameter int MSR_W      = 32,
    parameter int STEP_BIT   = 10,
    parameter int BRANCH_BIT = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MSR_W-1:0] msr_in,
    input  logic             cmp_valid,
    input  logic             cmp_branch,
    input  logic             cmp_fault,
    input  logic             exc_active,
    output logic             trace_req,
    output logic [VEC_W-1:0] trace_vec
);
    trace_en_t en_q;
    logic      fire;

    trace_enable_gate #(
        .MSR_W     (MSR_W),
        .STEP_BIT  (STEP_BIT),
        .BRANCH_BIT(BRANCH_BIT)
    ) u_gate (
        .msr_in    (msr_in),
        .exc_active(exc_active),
        .en_out    (en_q)
    );

    trace_event_select u_sel (
        .cmp_valid (cmp_valid),
        .cmp_branch(cmp_branch),
        .cmp_fault (cmp_fault),
        .en_in     (en_q),
        .fire      (fire)
    );

    trace_request_reg u_req (
        .clk  (clk),
        .rst_n(rst_n),
        .fire (fire),
        .req  (trace_req),
        .vec  (trace_vec)
    );
endmodule

// File: rtl/trace_trigger_chk.sv
`timescale 1ns/1ps
// Module: property checker for the trace trigger, bound to the top.
module trace_trigger_chk
    import trace_trig_pkg::*;
#(
    parameter int MSR_W      = 32,
    parameter int STEP_BIT   = 10,
    parameter int BRANCH_BIT = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic [MSR_W-1:0] msr_in,
    input logic             cmp_valid,
    input logic             cmp_branch,
    input logic             cmp_fault,
    input logic             exc_active,
    input logic             trace_req,
    input logic [VEC_W-1:0] trace_vec
);
    AST_VEC_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        trace_vec == (trace_req ? TRACE_VEC_OFF : '0)); // R7

    AST_REQ_NEEDS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        trace_req |-> $past(cmp_valid && !cmp_fault && !exc_active)); // R5

    AST_STEP_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !cmp_fault && !exc_active && msr_in[STEP_BIT]) |=> trace_req); // R2

    AST_BRANCH_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !cmp_fault && !exc_active && cmp_branch && msr_in[BRANCH_BIT])
        |=> trace_req); // R3

    AST_NO_ENABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!msr_in[STEP_BIT] && !(msr_in[BRANCH_BIT] && cmp_branch)) |=> !trace_req); // R4

    AST_EXC_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        exc_active |=> !trace_req); // R9
endmodule

bind trace_trigger trace_trigger_chk #(
    .MSR_W     (MSR_W),
    .STEP_BIT  (STEP_BIT),
    .BRANCH_BIT(BRANCH_BIT)
) u_chk (.*);

// File: tb/test_trace_trigger.sv
`timescale 1ns/1ps
// Bench: drives the trigger on the falling edge, predicts the outputs
// behaviourally and compares them on every cycle.
module test_trace_trigger;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] msr_in = '0;
    logic        cmp_valid = 1'b0, cmp_branch = 1'b0, cmp_fault = 1'b0, exc_active = 1'b0;
    logic        trace_req;
    logic [19:0] trace_vec;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    trace_trigger i_trace_trigger (
        .clk(clk), .rst_n(rst_n), .msr_in(msr_in),
        .cmp_valid(cmp_valid), .cmp_branch(cmp_branch), .cmp_fault(cmp_fault),
        .exc_active(exc_active), .trace_req(trace_req), .trace_vec(trace_vec)
    );

    // Apply one cycle of stimulus, predict the outcome, compare after the edge.
    task automatic step(input string tag, input bit rst, input logic [31:0] msr,
                        input bit v, input bit br, input bit f, input bit x);
        bit exp_req;
        int exp_vec;
        rst_n = rst; msr_in = msr; cmp_valid = v; cmp_branch = br;
        cmp_fault = f; exc_active = x;
        exp_req = rst && v && !f && !x && (msr[10] || (msr[9] && br));
        exp_vec = exp_req ? 32'h00D00 : 0;
        @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (trace_req !== exp_req || trace_vec !== exp_vec[19:0]) begin
            n_bad++;
            $display("FAIL %s: req=%0b vec=%h expected req=%0b vec=%h",
                     tag, trace_req, trace_vec, exp_req, exp_vec[19:0]);
        end
    endtask

    localparam logic [31:0] STEP = 32'h0000_0400;
    localparam logic [31:0] BRN  = 32'h0000_0200;
    localparam logic [31:0] OTHER = ~(STEP | BRN);

    initial begin
        int lfsr = 32'h1ACE5;
        @(negedge clk);
        step("R1", 0, STEP | BRN, 1, 1, 0, 0);
        step("R1", 0, STEP, 1, 0, 0, 0);
        step("R4", 1, 0, 1, 0, 0, 0);
        step("R4", 1, 0, 1, 1, 0, 0);
        step("R2", 1, STEP, 1, 0, 0, 0);
        step("R2", 1, STEP, 1, 1, 0, 0);
        step("R6", 1, STEP, 0, 0, 0, 0);
        step("R3", 1, BRN, 1, 0, 0, 0);
        step("R3", 1, BRN, 1, 1, 0, 0);
        step("R6", 1, STEP | BRN, 1, 1, 0, 0);
        step("R6", 1, STEP | BRN, 0, 1, 0, 0);
        step("R5", 1, STEP | BRN, 1, 1, 1, 0);
        step("R9", 1, STEP | BRN, 1, 1, 0, 1);
        step("R9", 1, STEP, 1, 0, 0, 1);
        step("R8", 1, 0, 0, 0, 0, 0);
        step("R8", 1, STEP, 1, 0, 0, 0);
        step("R8", 1, 0, 1, 0, 0, 0);
        step("R8", 1, BRN, 1, 1, 0, 0);
        step("R10", 1, OTHER, 1, 1, 0, 0);
        step("R10", 1, OTHER | STEP, 1, 0, 0, 0);
        step("R1", 0, STEP, 1, 0, 0, 0);
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step("R7", 1, {lfsr[31:11], lfsr[10:9], lfsr[8:0]},
                 lfsr[3] | lfsr[4], lfsr[5], lfsr[6] & lfsr[7], lfsr[12] & lfsr[13]);
        end
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule